// File: doc/BRIEF.md
# Transducer Channel Handshake Master

This block sits between a command decoder and one attached instrument module. It runs the master side of a per-channel handshake. The requester issues one of six operations. Each operation carries a byte count and an access code. The block then opens a transaction toward the slave. A transaction is framed by `ch_run` and `ch_end`. Inside that frame, each byte step is paced by `ch_exec` and acknowledged by `ch_done`. When the slave is configured as an event sensor, a rising edge on its event line opens a read transaction with no command.

The access code changes what the byte buses carry. When the code is zero, `ch_out` carries a data byte to write and `ch_in` carries a data byte read back. When the code is nonzero, `ch_out` carries an instruction code and `ch_in` carries the slave's reply code. Write bytes are fetched from the requester by step index. Captured bytes are returned one at a time. When the transaction closes, the slave's error code is translated into the block's own 4-bit status.

A divided channel clock sets the exchange rate. Every slave-facing output changes only on a rising edge of that clock. A programmable timeout aborts a transaction whose slave stops answering.

Top module: `chan_hs_master`

## Requirements
- R1: On launch, `ch_run` rises. It stays high until `ch_end` is seen high on a channel tick. On that tick `ch_run` falls, and `rsp_valid` pulses in the same cycle.
- R2: The block raises `ch_exec` only while `ch_run` is high and `ch_done` is low. Before it does, `ch_out` and `ch_acc` have been held for a full channel period. It drops `ch_exec` on the tick where `ch_done` is seen high. The next step waits until `ch_done` is seen low again.
- R3: A transaction makes exactly `cmd_len` byte steps. `ch_acc` equals `cmd_acc`, and `ch_out` and `ch_acc` hold steady while `ch_exec` is high. `ch_out` carries `wr_byte` for step `wr_idx` when the operation is write (3) or `cmd_acc` is nonzero; otherwise it carries 0. The byte on `ch_in` at each step is returned on `rd_byte` with a `rd_valid` pulse when the operation is read (2) or `cmd_acc` is nonzero; otherwise nothing is returned.
- R4: While `cfg_evt_sensor` is 1, a rising edge on `ch_evt` launches a read with access code 0 and EVT_LEN steps, and its response has `rsp_evt` = 1. While `cfg_evt_sensor` is 0, `ch_evt` has no effect.
- R5: On a normal close, the error code `ch_err` maps to the status as follows: 0→0 (ok), 1→4, 2→5, 3→6, and any other value →7.
- R6: Operation codes are init 0, update 1, read 2, write 3, start 4 and stop 5. A code above 5 is answered with status 2, and a write while `cfg_actuator` is 0 is answered with status 3. Both answers come in the cycle after acceptance, and `ch_run` is never raised for them.
- R7: Init first pulses `ch_rst` for one channel period with `ch_en` low, then runs its transaction. A start that closes with status 0 sets `ch_en`. A stop that closes on `ch_end` clears `ch_en`.
- R8: When `cfg_tmo` is nonzero, a wait for `ch_done` or `ch_end` that lasts longer than `cfg_tmo` ticks aborts the transaction. The abort drops `ch_run` and `ch_exec` and answers with status 1. When `cfg_tmo` is 0, a wait never aborts.
- R9: After `ch_run` falls, `cmd_ready` stays low until `ch_end` and `ch_done` are both seen low.
- R10: `ch_clk` toggles every CLK_HALF cycles. `ch_run`, `ch_exec`, `ch_out`, `ch_acc`, `ch_en` and `ch_rst` change only on its rising edges.
- R11: During reset, all slave-facing strobes and `ch_en` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_actuator | input | 1 | Channel may be written |
| cfg_evt_sensor | input | 1 | Slave event line may start a read |
| cfg_tmo | input | TMO_W | Timeout in channel ticks, 0 disables |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle and accepting |
| cmd_op | input | 3 | Operation code |
| cmd_len | input | LEN_W | Number of byte steps |
| cmd_acc | input | ACC_W | Access code for the transaction |
| wr_idx | output | LEN_W | Step index whose write byte is wanted |
| wr_byte | input | 8 | Write byte for `wr_idx` |
| rd_valid | output | 1 | Captured byte valid |
| rd_byte | output | 8 | Captured byte |
| rsp_valid | output | 1 | Completion pulse |
| rsp_status | output | 4 | Completion status |
| rsp_evt | output | 1 | Completion was event-started |
| ch_clk | output | 1 | Channel clock |
| ch_run | output | 1 | Transaction frame |
| ch_exec | output | 1 | Byte step request |
| ch_out | output | 8 | Data or instruction byte to slave |
| ch_acc | output | ACC_W | Access code to slave |
| ch_en | output | 1 | Slave enable |
| ch_rst | output | 1 | Slave reset |
| ch_end | input | 1 | Slave closes transaction |
| ch_done | input | 1 | Slave finished byte step |
| ch_in | input | 8 | Data or reply byte from slave |
| ch_evt | input | 1 | Slave event |
| ch_err | input | ERR_W | Slave error code |

## Verification
The assertions assume a well-behaved slave. It raises `ch_done` only while `ch_exec` is high and lowers it only after `ch_exec` has fallen. It raises `ch_end` only while `ch_run` is high with no step open, and lowers it only after `ch_run` has fallen. They also assume that `cfg_tmo` and the other configuration inputs stay constant during a transaction. The bench slave model obeys these rules by construction. Its random delays only stretch the time before each edge and never reorder the edges. Configuration changes happen only while the block is idle. Each stall case withholds one answer outright rather than sending an answer out of order.

// File: rtl/chs_pkg.sv
// Shared types for the channel handshake master.
// Assumes a 3-bit operation field and a 4-bit status field.
package chs_pkg;

    typedef enum logic [2:0] {
        OP_INIT   = 3'd0,
        OP_UPDATE = 3'd1,
        OP_READ   = 3'd2,
        OP_WRITE  = 3'd3,
        OP_START  = 3'd4,
        OP_STOP   = 3'd5
    } chs_op_e;

    localparam logic [2:0] OP_LAST = 3'd5;

    localparam logic [3:0] ST_OK      = 4'd0;
    localparam logic [3:0] ST_TIMEOUT = 4'd1;
    localparam logic [3:0] ST_BAD_OP  = 4'd2;
    localparam logic [3:0] ST_NOT_ACT = 4'd3;
    localparam logic [3:0] ST_BUSY    = 4'd4;
    localparam logic [3:0] ST_RANGE   = 4'd5;
    localparam logic [3:0] ST_FAULT   = 4'd6;
    localparam logic [3:0] ST_SLAVE   = 4'd7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RSTP,
        S_LAUNCH,
        S_SETTLE,
        S_EXEC,
        S_DLOW,
        S_WEND,
        S_REL
    } chs_state_e;

endpackage

// File: rtl/chs_clkgen.sv
// Channel clock generator.
// Toggles ch_clk every HALF system cycles. Emits tick in the cycle whose
// closing edge raises ch_clk, so logic enabled by tick moves with that edge.
// Assumes HALF >= 1.
module chs_clkgen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic ch_clk,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] PH_TOP = CW'(HALF - 1);

    logic [CW-1:0] phase_q;
    logic          clk_q;

    // Phase counter and channel clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            clk_q   <= 1'b0;
        end else if (phase_q == PH_TOP) begin
            phase_q <= '0;
            clk_q   <= ~clk_q;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign ch_clk = clk_q;
    assign tick   = (phase_q == PH_TOP) && !clk_q;

    assert_tick_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> $rose(clk_q));

endmodule

// File: rtl/chs_timeout.sv
// Wait-time counter.
// Counts channel ticks spent in a waiting state without progress and flags
// expiry once the count passes a nonzero limit. A zero limit never expires.
// Assumes the limit is constant while waiting.
module chs_timeout #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         waiting,
    input  logic         progress,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Count ticks while waiting; clear on progress or when not waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!waiting || (tick && progress)) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (limit != '0) && (cnt_q >= limit);

    assert_count_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !waiting |=> (cnt_q == '0));

endmodule

// File: rtl/chs_status_map.sv
// Slave error to status translation.
// Maps the slave's raw error code onto the block's 4-bit status values.
// Assumes ERR_W >= 2.
module chs_status_map
    import chs_pkg::*;
#(
    parameter int ERR_W = 3
) (
    input  logic [ERR_W-1:0] err,
    output logic [3:0]       status
);
    // Fixed code translation.
    always_comb begin
        if (err == '0)                 status = ST_OK;
        else if (err == ERR_W'(1))     status = ST_BUSY;
        else if (err == ERR_W'(2))     status = ST_RANGE;
        else if (err == ERR_W'(3))     status = ST_FAULT;
        else                           status = ST_SLAVE;
    end

endmodule

// File: rtl/chan_hs_master.sv
// Transducer channel handshake master.
// Accepts one operation at a time and runs a run/end framed transaction with
// exec/done paced byte steps. All slave-facing outputs move on channel clock
// rising edges. Assumes the slave follows the handshake order, that the
// requester supplies wr_byte combinationally for wr_idx, and that the cfg_*
// inputs are constant during a transaction.
module chan_hs_master
    import chs_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int ACC_W    = 4,
    parameter int ERR_W    = 3,
    parameter int TMO_W    = 16,
    parameter int CLK_HALF = 2,
    parameter int EVT_LEN  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_actuator,
    input  logic             cfg_evt_sensor,
    input  logic [TMO_W-1:0] cfg_tmo,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [ACC_W-1:0] cmd_acc,
    output logic [LEN_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    output logic             rd_valid,
    output logic [7:0]       rd_byte,
    output logic             rsp_valid,
    output logic [3:0]       rsp_status,
    output logic             rsp_evt,
    output logic             ch_clk,
    output logic             ch_run,
    output logic             ch_exec,
    output logic [7:0]       ch_out,
    output logic [ACC_W-1:0] ch_acc,
    output logic             ch_en,
    output logic             ch_rst,
    input  logic             ch_end,
    input  logic             ch_done,
    input  logic [7:0]       ch_in,
    input  logic             ch_evt,
    input  logic [ERR_W-1:0] ch_err
);
    localparam logic [LEN_W-1:0] EVT_LEN_V = LEN_W'(EVT_LEN);

    chs_state_e       state_q;
    logic [2:0]       op_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] step_q;
    logic [ACC_W-1:0] acc_q;
    logic             evt_src_q;
    logic             evt_d_q;
    logic             evt_pend_q;
    logic             run_q, exec_q, en_q, srst_q;
    logic [7:0]       out_q;
    logic [ACC_W-1:0] acc_out_q;
    logic             rd_v_q, rsp_v_q, rsp_evt_q;
    logic [7:0]       rd_q;
    logic [3:0]       rsp_st_q;

    logic       tick;
    logic       expired;
    logic       waiting;
    logic       progress;
    logic       drive_out;
    logic       take_in;
    logic       evt_rise;
    logic [7:0] out_pick;
    logic [3:0] mapped_st;

    chs_clkgen #(.HALF(CLK_HALF)) clkgen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ch_clk (ch_clk),
        .tick   (tick)
    );

    chs_timeout #(.W(TMO_W)) tmo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .waiting  (waiting),
        .progress (progress),
        .limit    (cfg_tmo),
        .expired  (expired)
    );

    chs_status_map #(.ERR_W(ERR_W)) map_i (
        .err    (ch_err),
        .status (mapped_st)
    );

    assign drive_out = (op_q == OP_WRITE) || (acc_q != '0);
    assign take_in   = (op_q == OP_READ)  || (acc_q != '0);
    assign out_pick  = drive_out ? wr_byte : 8'h00;
    assign evt_rise  = ch_evt && !evt_d_q;
    assign waiting   = (state_q == S_EXEC) || (state_q == S_DLOW) || (state_q == S_WEND);
    assign progress  = ((state_q == S_EXEC) && ch_done)
                    || ((state_q == S_DLOW) && !ch_done)
                    || ((state_q == S_WEND) && ch_end);

    assign cmd_ready = (state_q == S_IDLE) && !(evt_pend_q && cfg_evt_sensor);

    // Transaction sequencer: command acceptance, steps, close and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_q       <= 3'd0;
            len_q      <= '0;
            step_q     <= '0;
            acc_q      <= '0;
            evt_src_q  <= 1'b0;
            evt_d_q    <= 1'b0;
            evt_pend_q <= 1'b0;
            run_q      <= 1'b0;
            exec_q     <= 1'b0;
            en_q       <= 1'b0;
            srst_q     <= 1'b0;
            out_q      <= 8'h00;
            acc_out_q  <= '0;
            rd_v_q     <= 1'b0;
            rd_q       <= 8'h00;
            rsp_v_q    <= 1'b0;
            rsp_st_q   <= ST_OK;
            rsp_evt_q  <= 1'b0;
        end else begin
            rd_v_q  <= 1'b0;
            rsp_v_q <= 1'b0;
            evt_d_q <= ch_evt;
            case (state_q)
                S_IDLE: begin
                    if (evt_pend_q && cfg_evt_sensor) begin
                        op_q       <= OP_READ;
                        len_q      <= EVT_LEN_V;
                        acc_q      <= '0;
                        step_q     <= '0;
                        evt_src_q  <= 1'b1;
                        evt_pend_q <= 1'b0;
                        state_q    <= S_LAUNCH;
                    end else if (cmd_valid) begin
                        op_q      <= cmd_op;
                        len_q     <= cmd_len;
                        acc_q     <= cmd_acc;
                        step_q    <= '0;
                        evt_src_q <= 1'b0;
                        if (cmd_op > OP_LAST) begin
                            rsp_v_q   <= 1'b1;
                            rsp_st_q  <= ST_BAD_OP;
                            rsp_evt_q <= 1'b0;
                        end else if ((cmd_op == OP_WRITE) && !cfg_actuator) begin
                            rsp_v_q   <= 1'b1;
                            rsp_st_q  <= ST_NOT_ACT;
                            rsp_evt_q <= 1'b0;
                        end else if (cmd_op == OP_INIT) begin
                            state_q <= S_RSTP;
                        end else begin
                            state_q <= S_LAUNCH;
                        end
                    end
                end
                S_RSTP: begin
                    if (tick) begin
                        if (!srst_q) begin
                            srst_q <= 1'b1;
                            en_q   <= 1'b0;
                        end else begin
                            srst_q  <= 1'b0;
                            state_q <= S_LAUNCH;
                        end
                    end
                end
                S_LAUNCH: begin
                    if (tick) begin
                        run_q     <= 1'b1;
                        acc_out_q <= acc_q;
                        out_q     <= out_pick;
                        state_q   <= (len_q == '0) ? S_WEND : S_SETTLE;
                    end
                end
                S_SETTLE: begin
                    if (tick) begin
                        exec_q  <= 1'b1;
                        state_q <= S_EXEC;
                    end
                end
                S_EXEC: begin
                    if (tick) begin
                        if (ch_done) begin
                            exec_q <= 1'b0;
                            step_q <= step_q + 1'b1;
                            if (take_in) begin
                                rd_v_q <= 1'b1;
                                rd_q   <= ch_in;
                            end
                            state_q <= S_DLOW;
                        end else if (expired) begin
                            run_q     <= 1'b0;
                            exec_q    <= 1'b0;
                            rsp_v_q   <= 1'b1;
                            rsp_st_q  <= ST_TIMEOUT;
                            rsp_evt_q <= evt_src_q;
                            state_q   <= S_REL;
                        end
                    end
                end
                S_DLOW: begin
                    if (tick) begin
                        if (!ch_done) begin
                            if (step_q == len_q) begin
                                state_q <= S_WEND;
                            end else begin
                                out_q   <= out_pick;
                                state_q <= S_SETTLE;
                            end
                        end else if (expired) begin
                            run_q     <= 1'b0;
                            rsp_v_q   <= 1'b1;
                            rsp_st_q  <= ST_TIMEOUT;
                            rsp_evt_q <= evt_src_q;
                            state_q   <= S_REL;
                        end
                    end
                end
                S_WEND: begin
                    if (tick) begin
                        if (ch_end) begin
                            run_q     <= 1'b0;
                            rsp_v_q   <= 1'b1;
                            rsp_st_q  <= mapped_st;
                            rsp_evt_q <= evt_src_q;
                            if ((op_q == OP_START) && (mapped_st == ST_OK)) en_q <= 1'b1;
                            if (op_q == OP_STOP) en_q <= 1'b0;
                            state_q <= S_REL;
                        end else if (expired) begin
                            run_q     <= 1'b0;
                            rsp_v_q   <= 1'b1;
                            rsp_st_q  <= ST_TIMEOUT;
                            rsp_evt_q <= evt_src_q;
                            state_q   <= S_REL;
                        end
                    end
                end
                S_REL: begin
                    if (tick && !ch_end && !ch_done) state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
            if (evt_rise && cfg_evt_sensor) evt_pend_q <= 1'b1;
        end
    end

    assign wr_idx     = step_q;
    assign rd_valid   = rd_v_q;
    assign rd_byte    = rd_q;
    assign rsp_valid  = rsp_v_q;
    assign rsp_status = rsp_st_q;
    assign rsp_evt    = rsp_evt_q;
    assign ch_run     = run_q;
    assign ch_exec    = exec_q;
    assign ch_out     = out_q;
    assign ch_acc     = acc_out_q;
    assign ch_en      = en_q;
    assign ch_rst     = srst_q;

    assert_run_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ch_run) |-> rsp_valid);

    assert_exec_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ch_exec |-> ch_run);

    assert_out_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_exec) |-> ($stable(ch_out) && $stable(ch_acc)));

    assert_out_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_exec && $past(ch_exec)) |-> ($stable(ch_out) && $stable(ch_acc)));

    assert_reset_no_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ch_rst |-> !ch_en);

    assert_tmo_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_status == ST_TIMEOUT)) |-> (cfg_tmo != '0));

    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!ch_run && !ch_exec));

endmodule

// File: tb/chan_hs_master_tb_top.sv
// Bench: behavioural slave with random delays, per-clock protocol model,
// and per-command checks of bytes, step counts and status.
module chan_hs_master_tb_top;
    import chs_pkg::*;

    localparam int LEN_W = 8;
    localparam int ACC_W = 4;
    localparam int ERR_W = 3;
    localparam int TMO_W = 16;
    localparam int HALF  = 2;
    localparam int EVT_N = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             cfg_actuator = 1'b1;
    logic             cfg_evt_sensor = 1'b0;
    logic [TMO_W-1:0] cfg_tmo = 16'd20;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [2:0]       cmd_op = 3'd0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic [ACC_W-1:0] cmd_acc = '0;
    logic [LEN_W-1:0] wr_idx;
    logic [7:0]       wr_byte;
    logic             rd_valid;
    logic [7:0]       rd_byte;
    logic             rsp_valid;
    logic [3:0]       rsp_status;
    logic             rsp_evt;
    logic             ch_clk, ch_run, ch_exec, ch_en, ch_rst;
    logic [7:0]       ch_out;
    logic [ACC_W-1:0] ch_acc;

    bit               sl_end = 0, sl_done = 0, evt_drv = 0;
    logic [7:0]       sl_in = 8'h00;
    logic [ERR_W-1:0] sl_err = '0;

    chan_hs_master #(
        .LEN_W(LEN_W), .ACC_W(ACC_W), .ERR_W(ERR_W), .TMO_W(TMO_W),
        .CLK_HALF(HALF), .EVT_LEN(EVT_N)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_actuator(cfg_actuator), .cfg_evt_sensor(cfg_evt_sensor), .cfg_tmo(cfg_tmo),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_len(cmd_len), .cmd_acc(cmd_acc),
        .wr_idx(wr_idx), .wr_byte(wr_byte),
        .rd_valid(rd_valid), .rd_byte(rd_byte),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_evt(rsp_evt),
        .ch_clk(ch_clk), .ch_run(ch_run), .ch_exec(ch_exec), .ch_out(ch_out),
        .ch_acc(ch_acc), .ch_en(ch_en), .ch_rst(ch_rst),
        .ch_end(sl_end), .ch_done(sl_done), .ch_in(sl_in), .ch_evt(evt_drv),
        .ch_err(sl_err)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Stimulus context shared with the slave model.
    logic [7:0]       wr_salt = 8'h00;
    logic [2:0]       cur_op = 3'd0;
    logic [ACC_W-1:0] cur_acc = '0;
    int               exp_len = 0;
    int               sl_steps = 0;
    int               sl_dly = 0;
    bit               stall_done = 0, stall_end = 0;
    logic [7:0]       rd_exp[$];
    bit               rsp_seen = 0;
    logic [3:0]       got_st = 4'd0;
    bit               got_evt = 0;
    bit               rst_seen = 0;

    // Monitor history.
    bit               p_clk = 0, p_run = 0, p_exec = 0, clk_first = 0;
    logic [7:0]       p_out = 8'h00;
    logic [ACC_W-1:0] p_acc = '0;
    bit               p_en = 0, p_rst = 0;
    int               clk_cnt = 0;

    function automatic logic [7:0] wr_fn(input int i);
        return 8'(8'h3C + i * 29) ^ wr_salt;
    endfunction

    assign wr_byte = wr_fn(int'(wr_idx));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int rnd();
        return int'($urandom_range(0, 4));
    endfunction

    // Per-clock protocol model and slave, evaluated away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ch_clk != p_clk) begin
                if (clk_first) check(clk_cnt == HALF, "R10", "ch_clk half period", clk_cnt, HALF);
                clk_first = 1;
                clk_cnt = 1;
            end else begin
                clk_cnt++;
            end
            if ((ch_run != p_run) || (ch_exec != p_exec) || (ch_out != p_out) ||
                (ch_acc != p_acc) || (ch_en != p_en) || (ch_rst != p_rst))
                check(ch_clk && !p_clk, "R10", "output moved off rising ch_clk", int'(ch_clk), 1);
            if (ch_exec) check(ch_run, "R2", "exec without run", int'(ch_run), 1);
            if (ch_exec && !p_exec) check(!sl_done, "R2", "exec raised with done high", int'(sl_done), 0);
            if (!ch_exec && p_exec)
                check(sl_done || (rsp_valid && rsp_status == ST_TIMEOUT), "R2",
                      "exec dropped without done", int'(sl_done), 1);
            if (ch_exec && p_exec)
                check(ch_out == p_out && ch_acc == p_acc, "R3", "bus moved during exec",
                      int'(ch_out), int'(p_out));
            if (!ch_run && p_run) begin
                check(rsp_valid, "R1", "run fell without response", int'(rsp_valid), 1);
                check(sl_end || (rsp_status == ST_TIMEOUT), "R1", "run fell before end",
                      int'(sl_end), 1);
            end
            if (cmd_ready)
                check(!sl_end && !sl_done && !ch_run, "R9", "ready while slave busy",
                      int'({sl_end, sl_done, ch_run}), 0);
            if (ch_rst) begin
                rst_seen = 1;
                check(!ch_en, "R7", "enable high during slave reset", int'(ch_en), 0);
            end
            if (ch_run && !p_run && cur_op == OP_INIT)
                check(rst_seen, "R7", "init run without reset pulse", int'(rst_seen), 1);
            if (rd_valid) begin
                if (rd_exp.size() == 0) begin
                    check(0, "R3", "unexpected returned byte", int'(rd_byte), 0);
                end else begin
                    logic [7:0] e;
                    e = rd_exp.pop_front();
                    check(rd_byte == e, "R3", "returned byte", int'(rd_byte), int'(e));
                end
            end
            if (rsp_valid) begin
                rsp_seen = 1;
                got_st = rsp_status;
                got_evt = rsp_evt;
            end

            // Slave model.
            if (sl_end) begin
                if (!ch_run) begin
                    if (sl_dly > 0) sl_dly--;
                    else begin sl_end = 0; sl_dly = rnd(); end
                end
            end else if (sl_done) begin
                if (!ch_exec) begin
                    if (sl_dly > 0) sl_dly--;
                    else begin sl_done = 0; sl_dly = rnd(); end
                end
            end else if (ch_run && ch_exec) begin
                if (!stall_done) begin
                    if (sl_dly > 0) sl_dly--;
                    else begin
                        logic [7:0] eo;
                        bit drv, take;
                        drv  = (cur_op == OP_WRITE) || (cur_acc != '0);
                        take = (cur_op == OP_READ) || (cur_acc != '0);
                        eo = drv ? wr_fn(sl_steps) : 8'h00;
                        check(ch_out == eo, "R3", "out byte at step", int'(ch_out), int'(eo));
                        check(ch_acc == cur_acc, "R3", "access code", int'(ch_acc), int'(cur_acc));
                        sl_in = 8'($urandom);
                        if (take) rd_exp.push_back(sl_in);
                        sl_done = 1;
                        sl_steps++;
                        sl_dly = rnd();
                    end
                end
            end else if (ch_run && !ch_exec && sl_steps == exp_len && !stall_end) begin
                if (sl_dly > 0) sl_dly--;
                else begin sl_end = 1; sl_dly = rnd(); end
            end

            p_clk = ch_clk; p_run = ch_run; p_exec = ch_exec; p_out = ch_out;
            p_acc = ch_acc; p_en = ch_en; p_rst = ch_rst;
        end
    end

    task automatic issue(input logic [2:0] op, input int len, input logic [ACC_W-1:0] acc,
                         input logic [ERR_W-1:0] err);
        @(posedge clk); #1;
        while (!cmd_ready) begin @(posedge clk); #1; end
        cur_op = op; cur_acc = acc; exp_len = len; sl_steps = 0; sl_err = err;
        rd_exp.delete(); rsp_seen = 0; rst_seen = 0; wr_salt = 8'($urandom);
        cmd_valid = 1; cmd_op = op; cmd_len = LEN_W'(len); cmd_acc = acc;
        @(posedge clk); #1;
        cmd_valid = 0;
    endtask

    task automatic wait_rsp();
        while (!rsp_seen) begin @(posedge clk); #1; end
    endtask

    task automatic run_cmd(input logic [2:0] op, input int len, input logic [ACC_W-1:0] acc,
                           input logic [ERR_W-1:0] err, input logic [3:0] exp_st,
                           input string req);
        issue(op, len, acc, err);
        wait_rsp();
        check(got_st == exp_st, req, "status", int'(got_st), int'(exp_st));
        check(!got_evt, "R4", "event flag on command", int'(got_evt), 0);
        if (exp_st != ST_TIMEOUT && exp_st != ST_BAD_OP && exp_st != ST_NOT_ACT) begin
            check(sl_steps == len, "R3", "step count", sl_steps, len);
            check(rd_exp.size() == 0, "R3", "bytes left unreturned", rd_exp.size(), 0);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check(!ch_run && !ch_exec && !ch_en && !ch_rst && !rsp_valid && !rd_valid, "R11",
              "outputs in reset", int'({ch_run, ch_exec, ch_en, ch_rst}), 0);
        check(cmd_ready, "R11", "ready in reset", int'(cmd_ready), 1);
        rst_n = 1;

        run_cmd(OP_UPDATE, 3, 4'h0, 3'd0, ST_OK, "R1");
        run_cmd(OP_WRITE, 4, 4'h0, 3'd0, ST_OK, "R3");
        run_cmd(OP_READ, 5, 4'h0, 3'd0, ST_OK, "R3");
        run_cmd(OP_UPDATE, 2, 4'h9, 3'd0, ST_OK, "R3");
        run_cmd(OP_READ, 0, 4'h0, 3'd0, ST_OK, "R1");

        run_cmd(OP_START, 1, 4'h2, 3'd0, ST_OK, "R7");
        check(ch_en, "R7", "enable after start", int'(ch_en), 1);
        run_cmd(OP_STOP, 1, 4'h3, 3'd0, ST_OK, "R7");
        check(!ch_en, "R7", "enable after stop", int'(ch_en), 0);
        run_cmd(OP_START, 0, 4'h0, 3'd0, ST_OK, "R7");
        run_cmd(OP_INIT, 2, 4'h1, 3'd0, ST_OK, "R7");
        check(rst_seen, "R7", "init reset pulse", int'(rst_seen), 1);
        check(!ch_en, "R7", "enable after init", int'(ch_en), 0);
        run_cmd(OP_START, 0, 4'h0, 3'd2, ST_RANGE, "R5");
        check(!ch_en, "R7", "enable after failed start", int'(ch_en), 0);

        run_cmd(OP_UPDATE, 1, 4'h0, 3'd1, ST_BUSY, "R5");
        run_cmd(OP_UPDATE, 1, 4'h0, 3'd3, ST_FAULT, "R5");
        run_cmd(OP_UPDATE, 1, 4'h0, 3'd5, ST_SLAVE, "R5");

        run_cmd(3'd6, 2, 4'h0, 3'd0, ST_BAD_OP, "R6");
        check(!ch_run, "R6", "run on bad op", int'(ch_run), 0);
        cfg_actuator = 0;
        run_cmd(OP_WRITE, 2, 4'h0, 3'd0, ST_NOT_ACT, "R6");
        check(!ch_run, "R6", "run on write to sensor", int'(ch_run), 0);
        cfg_actuator = 1;

        stall_done = 1;
        run_cmd(OP_READ, 3, 4'h0, 3'd0, ST_TIMEOUT, "R8");
        check(!ch_run && !ch_exec, "R8", "strobes after abort", int'({ch_run, ch_exec}), 0);
        stall_done = 0;
        stall_end = 1;
        run_cmd(OP_WRITE, 2, 4'h0, 3'd0, ST_TIMEOUT, "R8");
        stall_end = 0;

        cfg_tmo = '0;
        stall_end = 1;
        issue(OP_UPDATE, 1, 4'h0, 3'd0);
        repeat (400) @(posedge clk);
        #1;
        check(!rsp_seen && ch_run, "R8", "abort with zero limit", int'(rsp_seen), 0);
        stall_end = 0;
        wait_rsp();
        check(got_st == ST_OK, "R8", "status after long wait", int'(got_st), int'(ST_OK));
        cfg_tmo = 16'd20;

        @(posedge clk); #1;
        while (!cmd_ready) begin @(posedge clk); #1; end
        rsp_seen = 0;
        evt_drv = 1;
        repeat (3) @(posedge clk);
        #1;
        evt_drv = 0;
        repeat (100) @(posedge clk);
        #1;
        check(!rsp_seen && !ch_run, "R4", "event ignored when not sensor", int'(rsp_seen), 0);

        cfg_evt_sensor = 1;
        cur_op = OP_READ; cur_acc = '0; exp_len = EVT_N; sl_steps = 0; sl_err = '0;
        rd_exp.delete(); rsp_seen = 0;
        evt_drv = 1;
        repeat (3) @(posedge clk);
        #1;
        evt_drv = 0;
        wait_rsp();
        check(got_evt, "R4", "event flag", int'(got_evt), 1);
        check(got_st == ST_OK, "R4", "event status", int'(got_st), int'(ST_OK));
        check(sl_steps == EVT_N, "R4", "event step count", sl_steps, EVT_N);
        check(rd_exp.size() == 0, "R4", "event bytes unreturned", rd_exp.size(), 0);
        cfg_evt_sensor = 0;

        for (int k = 0; k < 6; k++) begin
            run_cmd(OP_READ, k + 1, ACC_W'(k % 3), 3'd0, ST_OK, "R3");
        end

        repeat (20) @(posedge clk);
        finish_run();
    end

endmodule